// File: doc/BRIEF.md
# Eight-channel DAC code latch and update controller

The block sits between an 8-bit host register bus and eight 12-bit converter channels. Each channel holds two registers: an input latch that the host fills, and an output register that drives the converter code. A 12-bit code is built from two byte writes. The low byte is held in a staging register. Writing the high byte commits the whole code to the latch of the channel named by the select register. The outputs do not change at that point.

Latched codes move to the outputs when the host reads the data address. In normal mode a read transfers the adjacent pair that holds the selected channel (0/1, 2/3, 4/5, 6/7), and the partner channel reloads its own latch. With the broadcast bit of the select register set, one read transfers all eight channels together, and data commits are refused. A clear bit forces every output code to zero while it is set. An event input raises an interrupt flag, and a read of the high-byte address acknowledges it. A general-purpose 8-bit port has a direction bit for each pin.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After reset every output code is 0, the select register reads 0, `gpio_oe_o` is 0, `irq_o` is 0, and the control register (offset 4) reads 0.
- R2: A write at offset 0 stores the low byte in staging. A write at offset 1 commits {wdata[3:0], staged byte} into the latch of channel select[2:0]. wdata[7:4] is ignored. No output code changes.
- R3: When select[3]=0, a read at offset 0 loads outputs from latches for both channels c with c[2:1]=select[2:1], one cycle after the strobe. All other outputs keep their values.
- R4: When select[3]=1, a read at offset 0 loads all eight outputs from their latches in the same cycle, and a write at offset 1 leaves every latch unchanged.
- R5: A write at offset 2 stores wdata[3:0] as the select value (bit 3 = broadcast, bits 2..0 = channel). A read at offset 2 returns {4'b0, select}.
- R6: While control bit 0 (offset 4) is 1, all eight output codes read 0. Writing it back to 0 shows the stored output codes again.
- R7: A cycle with `event_i` high sets the flag seen on `irq_o` and at offset 4 bit 3 from the next cycle. A read at offset 1 clears the flag unless `event_i` is high in the same cycle, in which case the set wins.
- R8: Offset 5 holds the port direction (bit 1 = output), shown on `gpio_oe_o`. A write at offset 3 sets the port value, and `gpio_o` drives it only on output bits (0 on input bits). A read at offset 3 returns the driven value on output bits and `gpio_i` on input bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| event_i | input | 1 | Interrupt event |
| irq_o | output | 1 | Interrupt request flag |
| gpio_i | input | 8 | Port pin levels |
| gpio_o | output | 8 | Port drive value |
| gpio_oe_o | output | 8 | Port output enables |
| dac_code_o | output | 96 | Eight 12-bit output codes, channel n at bits [12n+11:12n] |

## Verification
On every cycle the assertions check the following. Output codes stay frozen unless a transfer read or a control write occurs, and a high-byte commit alone never moves them. A set clear bit zeroes them from the next cycle. The interrupt flag follows its set and acknowledge rules, the direction enables change only on their own write, and the select readback has a zero upper nibble. Which channels a transfer moves and which latch value each receives can only be shown by the bench's scenarios. The same holds for the ignored upper nibble, the refused commits in broadcast mode, the return of codes after clear, and the mixed readback of the port.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_GPIO = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd5;

  localparam int unsigned CLR_BIT = 0;
  localparam int unsigned IRQ_BIT = 3;
endpackage

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              xfer_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] latch_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      out_q   <= '0;
    end else begin
      if (we_i)   latch_q <= data_i;
      if (xfer_i) out_q   <= latch_q;
    end
  end

  assign code_o = clr_i ? '0 : out_q;
endmodule

// File: rtl/dac_host_regs.sv
module dac_host_regs
  import dac_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = dac_bank_pkg::NUM_CH,
  parameter int unsigned CODE_W = dac_bank_pkg::CODE_W,
  parameter int unsigned BUS_W  = dac_bank_pkg::BUS_W,
  localparam int unsigned IDX_W = $clog2(NUM_CH),
  localparam int unsigned SEL_W = IDX_W + 1,
  localparam int unsigned HI_W  = CODE_W - BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              event_i,
  output logic              irq_o,
  input  logic [BUS_W-1:0]  gpio_i,
  output logic [BUS_W-1:0]  gpio_o,
  output logic [BUS_W-1:0]  gpio_oe_o,
  output logic [NUM_CH-1:0] latch_we_o,
  output logic [CODE_W-1:0] latch_data_o,
  output logic [NUM_CH-1:0] xfer_o,
  output logic              clr_o
);
  logic [BUS_W-1:0] stage_lo_q, gout_q, dir_q;
  logic [SEL_W-1:0] sel_q;
  logic             clr_q, flag_q;

  logic wr_lo, wr_hi, wr_sel, wr_gpio, wr_ctrl, wr_dir, rd_lo, rd_hi;
  logic             bcast;
  logic [IDX_W-1:0] sel_idx;

  assign wr_lo   = wr_i && addr_i == OFS_LO;
  assign wr_hi   = wr_i && addr_i == OFS_HI;
  assign wr_sel  = wr_i && addr_i == OFS_SEL;
  assign wr_gpio = wr_i && addr_i == OFS_GPIO;
  assign wr_ctrl = wr_i && addr_i == OFS_CTRL;
  assign wr_dir  = wr_i && addr_i == OFS_DIR;
  assign rd_lo   = rd_i && addr_i == OFS_LO;
  assign rd_hi   = rd_i && addr_i == OFS_HI;

  assign bcast   = sel_q[IDX_W];
  assign sel_idx = sel_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_lo_q <= '0;
      sel_q      <= '0;
      gout_q     <= '0;
      dir_q      <= '0;
      clr_q      <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (wr_lo)   stage_lo_q <= wdata_i;
      if (wr_sel)  sel_q      <= wdata_i[SEL_W-1:0];
      if (wr_gpio) gout_q     <= wdata_i;
      if (wr_dir)  dir_q      <= wdata_i;
      if (wr_ctrl) clr_q      <= wdata_i[CLR_BIT];
      // event has priority over acknowledge
      if (event_i)    flag_q <= 1'b1;
      else if (rd_hi) flag_q <= 1'b0;
    end
  end

  assign latch_data_o = {wdata_i[HI_W-1:0], stage_lo_q};

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      latch_we_o[i] = wr_hi && !bcast && (sel_idx == IDX_W'(i));
      xfer_o[i]     = rd_lo && (bcast ||
                      (sel_idx[IDX_W-1:1] == (IDX_W-1)'(i >> 1)));
    end
  end

  logic [BUS_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CLR_BIT] = clr_q;
    ctrl_rd[IRQ_BIT] = flag_q;
  end

  always_comb begin
    unique case (addr_i)
      OFS_SEL:  rdata_o = {{(BUS_W-SEL_W){1'b0}}, sel_q};
      OFS_GPIO: rdata_o = (gout_q & dir_q) | (gpio_i & ~dir_q);
      OFS_CTRL: rdata_o = ctrl_rd;
      OFS_DIR:  rdata_o = dir_q;
      default:  rdata_o = '0;
    endcase
  end

  assign gpio_o    = gout_q & dir_q;
  assign gpio_oe_o = dir_q;
  assign irq_o     = flag_q;
  assign clr_o     = clr_q;
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
  import dac_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = dac_bank_pkg::NUM_CH,
  parameter int unsigned CODE_W = dac_bank_pkg::CODE_W,
  parameter int unsigned BUS_W  = dac_bank_pkg::BUS_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [BUS_W-1:0]         wdata_i,
  output logic [BUS_W-1:0]         rdata_o,
  input  logic                     event_i,
  output logic                     irq_o,
  input  logic [BUS_W-1:0]         gpio_i,
  output logic [BUS_W-1:0]         gpio_o,
  output logic [BUS_W-1:0]         gpio_oe_o,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o
);
  logic [NUM_CH-1:0] latch_we, xfer;
  logic [CODE_W-1:0] latch_data;
  logic              clr_w;

  dac_host_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .event_i, .irq_o, .gpio_i, .gpio_o, .gpio_oe_o,
    .latch_we_o(latch_we), .latch_data_o(latch_data),
    .xfer_o(xfer), .clr_o(clr_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk_i, .rst_ni,
      .we_i(latch_we[c]), .data_i(latch_data),
      .xfer_i(xfer[c]), .clr_i(clr_w),
      .code_o(dac_code_o[c*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dac_bank_ctrl_chk.sv
module dac_bank_ctrl_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned BUS_W  = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [2:0]               addr_i,
  input logic                     wr_i,
  input logic                     rd_i,
  input logic                     clr_bit_i,
  input logic [3:0]               rdata_hi_i,
  input logic                     event_i,
  input logic                     irq_o,
  input logic [BUS_W-1:0]         gpio_oe_o,
  input logic [NUM_CH*CODE_W-1:0] dac_code_o
);
  assert_commit_no_move_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == 3'd1) |=> $stable(dac_code_o));

  assert_hold_outputs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rd_i && addr_i == 3'd0) && !(wr_i && addr_i == 3'd4)) |=> $stable(dac_code_o));

  assert_sel_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd2) |-> (rdata_hi_i == 4'd0));

  assert_clear_zeroes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd4 && clr_bit_i) |=> (dac_code_o == '0));

  assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> irq_o);

  assert_irq_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd1 && !event_i) |=> !irq_o);

  assert_dir_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 3'd5) |=> $stable(gpio_oe_o));
endmodule

bind dac_bank_ctrl dac_bank_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .clr_bit_i(wdata_i[0]), .rdata_hi_i(rdata_o[7:4]), .event_i(event_i),
  .irq_o(irq_o), .gpio_oe_o(gpio_oe_o), .dac_code_o(dac_code_o)
);

// File: tb/dac_bank_ctrl_test.sv
module dac_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW  = 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, evt = 1'b0;
  logic [7:0]  wdata = '0, rdata, gpio_in = '0, gpio_out, gpio_oe;
  logic        irq;
  logic [NCH*CW-1:0] codes;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(evt), .irq_o(irq),
    .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe), .dac_code_o(codes)
  );

  // kinds: 0 channel code, 1 rdata, 2 irq, 3 gpio_o, 4 gpio_oe
  typedef struct { int kind; int idx; logic [11:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model from the requirements
  logic [11:0] m_latch [NCH];
  logic [11:0] m_out   [NCH];
  logic [7:0]  m_stage = '0, m_gout = '0, m_dir = '0;
  logic [3:0]  m_sel = '0;
  bit          m_clr = 0, m_flag = 0;

  task automatic push(int kind, int idx, logic [11:0] exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_codes(string tag);
    for (int i = 0; i < NCH; i++) push(0, i, m_clr ? 12'h000 : m_out[i], tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [11:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = codes[it.idx*CW +: CW];
          1: act = {4'h0, rdata};
          2: act = {11'h0, irq};
          3: act = {4'h0, gpio_out};
          default: act = {4'h0, gpio_oe};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                   it.tag, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      3'd0: m_stage = d;
      3'd1: if (!m_sel[3]) m_latch[m_sel[2:0]] = {d[3:0], m_stage};
      3'd2: m_sel = d[3:0];
      3'd3: m_gout = d;
      3'd4: m_clr = d[0];
      3'd5: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(logic [2:0] a, bit chk, logic [7:0] exp, string tag, bit with_evt = 0);
    @(negedge clk);
    addr = a; rd = 1'b1; evt = with_evt;
    if (chk) push(1, 0, {4'h0, exp}, tag);
    @(negedge clk);
    rd = 1'b0; evt = 1'b0;
    if (a == 3'd0) begin
      for (int i = 0; i < NCH; i++)
        if (m_sel[3] || (i[2:1] == m_sel[2:1])) m_out[i] = m_latch[i];
    end
    if (a == 3'd1 && !with_evt) m_flag = 0;
    if (with_evt) m_flag = 1;
  endtask

  task automatic write_code(int ch, logic [11:0] code);
    bus_wr(3'd2, 8'(ch));
    bus_wr(3'd0, code[7:0]);
    bus_wr(3'd1, {4'h0, code[11:8]});
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin m_latch[i] = '0; m_out[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    expect_codes("R1");
    push(2, 0, 12'h0, "R1");
    push(4, 0, 12'h0, "R1");
    bus_rd(3'd2, 1, 8'h00, "R1 select");
    bus_rd(3'd4, 1, 8'h00, "R1 control");

    // R2 commit with upper nibble garbage, outputs still zero
    bus_wr(3'd2, 8'h03);
    bus_wr(3'd0, 8'hA5);
    bus_wr(3'd1, 8'hF7);
    expect_codes("R2 no output move");

    // R3 pair 2/3 transfers, ch3 shows 7A5 (nibble ignored, R2)
    bus_rd(3'd0, 0, 8'h00, "");
    expect_codes("R3 pair 2/3");
    push(0, 3, 12'h7A5, "R2 code value");

    // R3 other pairs untouched; partner reloads own latch
    write_code(2, 12'h123);
    write_code(5, 12'h456);
    bus_rd(3'd0, 0, 8'h00, "");
    expect_codes("R3 pair 4/5");
    push(0, 2, 12'h000, "R3 ch2 not moved");
    bus_wr(3'd2, 8'h02);
    bus_rd(3'd0, 0, 8'h00, "");
    expect_codes("R3 pair 2/3 reload");

    // R4 broadcast
    for (int i = 0; i < NCH; i++) write_code(i, 12'((i * 12'h1A3 + 12'h05F)));
    bus_wr(3'd2, 8'h08);
    bus_wr(3'd0, 8'hEE);
    bus_wr(3'd1, 8'h0D);
    expect_codes("R4 before read");
    bus_rd(3'd0, 0, 8'h00, "");
    expect_codes("R4 all eight");
    for (int i = 0; i < NCH; i++) push(0, i, 12'((i * 12'h1A3 + 12'h05F)), "R4 commit refused");

    // R5 select readback
    bus_wr(3'd2, 8'hFA);
    bus_rd(3'd2, 1, 8'h0A, "R5 readback");
    bus_wr(3'd2, 8'h06);
    bus_rd(3'd2, 1, 8'h06, "R5 readback");

    // R6 clear forces zero, release restores
    bus_wr(3'd4, 8'h01);
    expect_codes("R6 cleared");
    for (int i = 0; i < NCH; i++) push(0, i, 12'h000, "R6 zero");
    bus_rd(3'd4, 1, 8'h01, "R6 control bit");
    bus_wr(3'd4, 8'h00);
    expect_codes("R6 restored");

    // R7 interrupt flag
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0; m_flag = 1;
    push(2, 0, 12'h1, "R7 set");
    bus_rd(3'd4, 1, 8'h08, "R7 flag bit3");
    bus_rd(3'd1, 0, 8'h00, "");
    push(2, 0, 12'h0, "R7 ack");
    bus_rd(3'd1, 0, 8'h00, "", 1);
    push(2, 0, 12'h1, "R7 set wins");
    bus_rd(3'd1, 0, 8'h00, "");
    push(2, 0, 12'h0, "R7 ack again");

    // R8 port
    gpio_in = 8'hC3;
    bus_wr(3'd3, 8'h5A);
    push(3, 0, 12'h000, "R8 all inputs");
    bus_wr(3'd5, 8'h0F);
    push(4, 0, 12'h00F, "R8 oe");
    push(3, 0, 12'h00A, "R8 drive");
    bus_rd(3'd3, 1, 8'hCA, "R8 mixed read");
    bus_rd(3'd5, 1, 8'h0F, "R8 dir read");
    expect_codes("R8 codes unaffected");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule